// File: doc/BRIEF.md
# Word-to-Burst Adapter

This block lets a requester that works on one 16-bit word at a time use a memory command path that always moves eight 16-bit beats per access. Each accepted request becomes one aligned burst. On a write, the word is copied into every beat, and a per-beat mask stores only the addressed word. On a read, the block counts the eight returned beats and keeps the one that holds the requested word. The memory returns its beats with a fixed rotation, and a parameter sets the size of that rotation.

Refresh requests go to the memory on their own command flag and never touch data. A two-bit status tells the requester when it may issue the next request. The memory side has these parts:

- a command handshake that carries the aligned column;
- a full eight-beat write payload with its mask;
- a completion pulse for writes and refreshes;
- a serial stream of returned read beats, each with a valid flag.

Top module: `word_burst_adapter`

## Requirements
- R1: While `rst_n` is low, `status` is 0 (reset). On the first rising edge after release, `status` becomes 1 (ready).
- R2: A request is taken at a rising edge where `req_valid` is 1 and `status` is 1. From the next cycle, `mem_cmd_valid` is 1 and `mem_cmd_col` equals `req_addr` with its three low bits cleared. Both stay that way until the edge where `mem_cmd_ready` is 1.
- R3: `status` is 2 (busy) from the cycle after a request is taken until that operation completes. A `req_valid` seen while busy is ignored: it issues no command and changes no memory word.
- R4: During a write, bit i of `mem_wmask` belongs to beat i. A 1 means the beat is ignored and a 0 means it is stored. Exactly one bit is 0, at i = `req_addr[2:0]`; for example, address 13 gives 1,1,1,1,1,0,1,1 for beats 0 to 7. When no write is in progress, all mask bits are 1.
- R5: During a write, every beat i of `mem_wdata` (bits 16i+15 down to 16i) equals the requested write word.
- R6: The mask, payload and column stay unchanged from the cycle after acceptance until the write completes.
- R7: After its command handshake, a write or refresh completes at the edge where `mem_done` is 1. `status` is 1 in the next cycle.
- R8: Read beats are numbered 0 to 7 in arrival order, and only cycles with `mem_rbeat_valid` set count. The returned word is beat (`req_addr[2:0]` + RD_SKEW) mod 8, with RD_SKEW = 3 by default. Cycles without a valid beat may fall between beats.
- R9: One cycle after the eighth beat, `rd_valid` is 1 for exactly one cycle with the selected word on `rd_data`. In the cycle after that, `status` is 1. At all other times `rd_valid` is 0.
- R10: When `req_refresh` is 1 in a taken request, it wins over `req_write`. The command carries `mem_cmd_refresh` = 1 and `mem_cmd_write` = 0, no memory word changes, and the operation completes as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Requester presents a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_refresh | input | 1 | Refresh request, wins over read and write |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | WORD_W | Word to write |
| status | output | 2 | 0 reset, 1 ready, 2 busy |
| rd_valid | output | 1 | One-cycle pulse: read word available |
| rd_data | output | WORD_W | Read word |
| mem_cmd_valid | output | 1 | Burst command pending |
| mem_cmd_write | output | 1 | Pending command is a write |
| mem_cmd_refresh | output | 1 | Pending command is a refresh |
| mem_cmd_col | output | ADDR_W | Burst-aligned column |
| mem_cmd_ready | input | 1 | Memory takes the command |
| mem_wdata | output | BEATS*WORD_W | Write payload, beat 0 in the low bits |
| mem_wmask | output | BEATS | Per-beat mask, 1 = ignore the beat |
| mem_done | input | 1 | Write or refresh finished |
| mem_rbeat_valid | input | 1 | A read beat is present |
| mem_rbeat_data | input | WORD_W | Read beat data |

## Verification
Writes are issued at every low-address offset inside one burst, and also at offsets in other bursts. This shows whether the single cleared mask bit follows the offset or is stuck in one place. Reads come back from a skewed memory model, some with a gap between beats and some without. A wrong rotation, or a beat counter that also counts idle cycles, returns a neighbouring word. A write attempted while the block is busy, and a refresh that also has the write flag set, are each followed by read-backs. These read-backs show whether the block let a request through that it should have dropped.

// File: rtl/wba_pkg.sv
package wba_pkg;
  typedef enum logic [1:0] {
    STAT_RESET = 2'd0,
    STAT_READY = 2'd1,
    STAT_BUSY  = 2'd2
  } stat_e;

  typedef enum logic [2:0] {
    PH_RESET, PH_IDLE, PH_CMD, PH_WAIT, PH_BEATS, PH_RET
  } phase_e;

  typedef enum logic [1:0] {
    OP_READ, OP_WRITE, OP_REFRESH
  } op_e;
endpackage

// File: rtl/wba_ctrl.sv
module wba_ctrl
  import wba_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_refresh,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic              mem_cmd_ready,
  input  logic              mem_done,
  input  logic              burst_last,
  output phase_e            phase,
  output op_e               op,
  output logic [ADDR_W-1:0] lat_addr,
  output logic [WORD_W-1:0] lat_wdata,
  output logic              take,
  output stat_e             status
);
  phase_e phase_nx;

  assign take = (phase == PH_IDLE) && req_valid;

  function automatic op_e decode_op(input logic refr, input logic wr);
    if (refr)    return OP_REFRESH;
    else if (wr) return OP_WRITE;
    else         return OP_READ;
  endfunction

  always_comb begin
    phase_nx = phase;
    unique case (phase)
      PH_RESET: phase_nx = PH_IDLE;
      PH_IDLE:  if (take) phase_nx = PH_CMD;
      PH_CMD:   if (mem_cmd_ready) phase_nx = (op == OP_READ) ? PH_BEATS : PH_WAIT;
      PH_WAIT:  if (mem_done) phase_nx = PH_IDLE;
      PH_BEATS: if (burst_last) phase_nx = PH_RET;
      PH_RET:   phase_nx = PH_IDLE;
      default:  phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_RESET;
      op        <= OP_READ;
      lat_addr  <= '0;
      lat_wdata <= '0;
    end else begin
      phase <= phase_nx;
      if (take) begin
        op        <= decode_op(req_refresh, req_write);
        lat_addr  <= req_addr;
        lat_wdata <= req_wdata;
      end
    end
  end

  always_comb begin
    unique case (phase)
      PH_RESET: status = STAT_RESET;
      PH_IDLE:  status = STAT_READY;
      default:  status = STAT_BUSY;
    endcase
  end
endmodule

// File: rtl/wba_write_pack.sv
module wba_write_pack #(
  parameter int WORD_W = 16,
  parameter int BEATS  = 8,
  localparam int IDX_W = $clog2(BEATS)
) (
  input  logic                    wr_active,
  input  logic [IDX_W-1:0]        lo_idx,
  input  logic [WORD_W-1:0]       word,
  output logic [BEATS*WORD_W-1:0] payload,
  output logic [BEATS-1:0]        mask
);
  function automatic logic [BEATS-1:0] keep_only(input logic [IDX_W-1:0] lo);
    logic [BEATS-1:0] m;
    m = '1;
    m[lo] = 1'b0;
    return m;
  endfunction

  for (genvar g = 0; g < BEATS; g++) begin : g_beat
    assign payload[g*WORD_W +: WORD_W] = word;
  end

  assign mask = wr_active ? keep_only(lo_idx) : '1;
endmodule

// File: rtl/wba_read_pick.sv
module wba_read_pick #(
  parameter int WORD_W  = 16,
  parameter int BEATS   = 8,
  parameter int RD_SKEW = 3,
  localparam int IDX_W  = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              collecting,
  input  logic [IDX_W-1:0]  lo_idx,
  input  logic              beat_valid,
  input  logic [WORD_W-1:0] beat_data,
  output logic [WORD_W-1:0] word,
  output logic              last
);
  logic [IDX_W-1:0] cnt;
  logic [IDX_W-1:0] sel;
  logic             beat_in;

  function automatic logic [IDX_W-1:0] skewed_beat(input logic [IDX_W-1:0] lo);
    int s;
    s = (int'(lo) + RD_SKEW) % BEATS;
    return IDX_W'(s);
  endfunction

  assign sel     = skewed_beat(lo_idx);
  assign beat_in = collecting && beat_valid;
  assign last    = beat_in && (cnt == IDX_W'(BEATS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      word <= '0;
    end else if (!collecting) begin
      cnt <= '0;
    end else if (beat_in) begin
      cnt <= cnt + 1'b1;
      if (cnt == sel) word <= beat_data;
    end
  end
endmodule

// File: rtl/word_burst_adapter.sv
module word_burst_adapter
  import wba_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int WORD_W  = 16,
  parameter int BEATS   = 8,
  parameter int RD_SKEW = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic                    req_refresh,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [WORD_W-1:0]       req_wdata,
  output logic [1:0]              status,
  output logic                    rd_valid,
  output logic [WORD_W-1:0]       rd_data,
  output logic                    mem_cmd_valid,
  output logic                    mem_cmd_write,
  output logic                    mem_cmd_refresh,
  output logic [ADDR_W-1:0]       mem_cmd_col,
  input  logic                    mem_cmd_ready,
  output logic [BEATS*WORD_W-1:0] mem_wdata,
  output logic [BEATS-1:0]        mem_wmask,
  input  logic                    mem_done,
  input  logic                    mem_rbeat_valid,
  input  logic [WORD_W-1:0]       mem_rbeat_data
);
  localparam int IDX_W = $clog2(BEATS);

  phase_e            phase;
  op_e               op;
  stat_e             stat;
  logic [ADDR_W-1:0] lat_addr;
  logic [WORD_W-1:0] lat_wdata;
  logic              take;
  logic              burst_last;
  logic              wr_hold;
  logic              collecting;

  wba_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_refresh(req_refresh),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .mem_cmd_ready(mem_cmd_ready), .mem_done(mem_done), .burst_last(burst_last),
    .phase(phase), .op(op), .lat_addr(lat_addr), .lat_wdata(lat_wdata),
    .take(take), .status(stat)
  );

  assign wr_hold    = (op == OP_WRITE) && ((phase == PH_CMD) || (phase == PH_WAIT));
  assign collecting = (phase == PH_BEATS);

  wba_write_pack #(.WORD_W(WORD_W), .BEATS(BEATS)) u_wpack (
    .wr_active(wr_hold), .lo_idx(lat_addr[IDX_W-1:0]), .word(lat_wdata),
    .payload(mem_wdata), .mask(mem_wmask)
  );

  wba_read_pick #(.WORD_W(WORD_W), .BEATS(BEATS), .RD_SKEW(RD_SKEW)) u_rpick (
    .clk(clk), .rst_n(rst_n), .collecting(collecting),
    .lo_idx(lat_addr[IDX_W-1:0]),
    .beat_valid(mem_rbeat_valid), .beat_data(mem_rbeat_data),
    .word(rd_data), .last(burst_last)
  );

  assign status          = stat;
  assign mem_cmd_valid   = (phase == PH_CMD);
  assign mem_cmd_write   = mem_cmd_valid && (op == OP_WRITE);
  assign mem_cmd_refresh = mem_cmd_valid && (op == OP_REFRESH);
  assign mem_cmd_col     = {lat_addr[ADDR_W-1:IDX_W], {IDX_W{1'b0}}};
  assign rd_valid        = (phase == PH_RET);
endmodule

// File: rtl/wba_checker.sv
module wba_checker #(
  parameter int ADDR_W = 16,
  parameter int WORD_W = 16,
  parameter int BEATS  = 8,
  localparam int IDX_W = $clog2(BEATS)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [1:0]              status,
  input logic                    req_valid,
  input logic                    mem_cmd_valid,
  input logic                    mem_cmd_write,
  input logic                    mem_cmd_refresh,
  input logic [ADDR_W-1:0]       mem_cmd_col,
  input logic [BEATS*WORD_W-1:0] mem_wdata,
  input logic [BEATS-1:0]        mem_wmask,
  input logic                    rd_valid,
  input logic                    wr_hold
);
  a_r2_col_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid |-> (mem_cmd_col[IDX_W-1:0] == '0));

  a_r2_cmd_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cmd_valid) |-> ($past(status) == 2'd1) && $past(req_valid));

  a_r3_busy_while_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid |-> (status == 2'd2));

  a_r4_one_beat_kept: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_write |-> ($countones(mem_wmask) == BEATS - 1));

  a_r4_idle_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hold |-> (mem_wmask == '1));

  a_r5_payload_repeated: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_write |-> (mem_wdata == {BEATS{mem_wdata[WORD_W-1:0]}}));

  a_r6_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hold && $past(wr_hold)) |-> ($stable(mem_wmask) && $stable(mem_wdata) && $stable(mem_cmd_col)));

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> (!rd_valid && (status == 2'd1)));

  a_r10_refresh_not_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_refresh |-> !mem_cmd_write);
endmodule

bind word_burst_adapter wba_checker #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .BEATS(BEATS)) u_chk (
  .clk(clk), .rst_n(rst_n), .status(status), .req_valid(req_valid),
  .mem_cmd_valid(mem_cmd_valid), .mem_cmd_write(mem_cmd_write),
  .mem_cmd_refresh(mem_cmd_refresh), .mem_cmd_col(mem_cmd_col),
  .mem_wdata(mem_wdata), .mem_wmask(mem_wmask), .rd_valid(rd_valid),
  .wr_hold(wr_hold)
);

// File: tb/word_burst_adapter_tb.sv
module word_burst_adapter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SKEW       = 3;
  localparam int NWORDS     = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0, req_write = 1'b0, req_refresh = 1'b0;
  logic [15:0]  req_addr = '0, req_wdata = '0;
  logic [1:0]   status;
  logic         rd_valid;
  logic [15:0]  rd_data;
  logic         mem_cmd_valid, mem_cmd_write, mem_cmd_refresh;
  logic [15:0]  mem_cmd_col;
  logic         mem_cmd_ready = 1'b0;
  logic [127:0] mem_wdata;
  logic [7:0]   mem_wmask;
  logic         mem_done = 1'b0;
  logic         mem_rbeat_valid = 1'b0;
  logic [15:0]  mem_rbeat_data = '0;

  int checks = 0;
  int errors = 0;
  logic [15:0] gold [NWORDS];
  logic [15:0] dram [NWORDS];

  always #(CLK_PERIOD/2) clk = ~clk;

  word_burst_adapter #(.RD_SKEW(SKEW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_refresh(req_refresh),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .status(status), .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_cmd_valid(mem_cmd_valid), .mem_cmd_write(mem_cmd_write),
    .mem_cmd_refresh(mem_cmd_refresh), .mem_cmd_col(mem_cmd_col),
    .mem_cmd_ready(mem_cmd_ready), .mem_wdata(mem_wdata), .mem_wmask(mem_wmask),
    .mem_done(mem_done), .mem_rbeat_valid(mem_rbeat_valid),
    .mem_rbeat_data(mem_rbeat_data)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ready();
    while (status != 2'd1) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_mask(input int addr);
    logic [7:0] m;
    for (int i = 0; i < 8; i++) m[i] = (i != (addr % 8));
    return m;
  endfunction

  task automatic do_write(input int addr, input logic [15:0] data, input bit poke_busy);
    logic [7:0]   m0;
    logic [127:0] p0;
    wait_ready();
    req_valid = 1; req_write = 1; req_refresh = 0; req_addr = 16'(addr); req_wdata = data;
    @(negedge clk);
    req_valid = 0;
    chk(mem_cmd_valid && mem_cmd_write && !mem_cmd_refresh, "R2 write cmd", mem_cmd_valid, 1);
    chk(mem_cmd_col == 16'(addr & ~7), "R2 column", mem_cmd_col, addr & ~7);
    chk(mem_wmask == exp_mask(addr), "R4 mask", mem_wmask, exp_mask(addr));
    chk(mem_wdata == {8{data}}, "R5 payload", mem_wdata, {8{data}});
    chk(status == 2'd2, "R3 busy", status, 2);
    m0 = mem_wmask; p0 = mem_wdata;
    if (poke_busy) begin
      req_valid = 1; req_write = 1; req_addr = 16'(addr ^ 1); req_wdata = ~data;
    end
    @(negedge clk);
    chk(mem_cmd_valid && mem_cmd_col == 16'(addr & ~7), "R2 cmd held", mem_cmd_valid, 1);
    mem_cmd_ready = 1;
    @(negedge clk);
    mem_cmd_ready = 0;
    chk(!mem_cmd_valid, "R2 cmd dropped after ready", mem_cmd_valid, 0);
    chk(mem_wmask == m0 && mem_wdata == p0, "R6 stable", mem_wmask, m0);
    chk(status == 2'd2, "R3 busy wait", status, 2);
    for (int b = 0; b < 8; b++)
      if (!mem_wmask[b]) dram[(addr & ~7) + b] = mem_wdata[b*16 +: 16];
    gold[addr] = data;
    @(negedge clk);
    mem_done = 1;
    @(negedge clk);
    mem_done = 0; req_valid = 0;
    chk(status == 2'd1, "R7 ready after done", status, 1);
    @(negedge clk);
    chk(!mem_cmd_valid && mem_wmask == 8'hff, "R3 busy request ignored", mem_cmd_valid, 0);
  endtask

  task automatic do_read(input int addr, input bit gap);
    int col;
    col = addr & ~7;
    wait_ready();
    req_valid = 1; req_write = 0; req_refresh = 0; req_addr = 16'(addr);
    @(negedge clk);
    req_valid = 0;
    chk(mem_cmd_valid && !mem_cmd_write && !mem_cmd_refresh, "R2 read cmd", mem_cmd_valid, 1);
    chk(mem_cmd_col == 16'(col), "R2 read column", mem_cmd_col, col);
    mem_cmd_ready = 1;
    @(negedge clk);
    mem_cmd_ready = 0;
    for (int b = 0; b < 8; b++) begin
      if (gap && (b == 2 || b == 5)) begin
        mem_rbeat_valid = 0;
        mem_rbeat_data = 16'hbad0;
        @(negedge clk);
      end
      mem_rbeat_valid = 1;
      mem_rbeat_data = dram[col + ((b - SKEW + 8) % 8)];
      @(negedge clk);
      if (b < 7) chk(!rd_valid, "R9 no early pulse", rd_valid, 0);
    end
    mem_rbeat_valid = 0;
    chk(rd_valid == 1'b1, "R9 pulse", rd_valid, 1);
    chk(rd_data == gold[addr], "R8 word", rd_data, gold[addr]);
    @(negedge clk);
    chk(!rd_valid && status == 2'd1, "R9 one cycle then ready", rd_valid, 0);
  endtask

  task automatic do_refresh();
    wait_ready();
    req_valid = 1; req_write = 1; req_refresh = 1; req_addr = 16'd9; req_wdata = 16'hffff;
    @(negedge clk);
    req_valid = 0; req_refresh = 0;
    chk(mem_cmd_refresh && !mem_cmd_write, "R10 refresh cmd", mem_cmd_refresh, 1);
    chk(mem_wmask == 8'hff, "R10 nothing stored", mem_wmask, 8'hff);
    mem_cmd_ready = 1;
    @(negedge clk);
    mem_cmd_ready = 0;
    @(negedge clk);
    chk(status == 2'd2, "R10 busy", status, 2);
    mem_done = 1;
    @(negedge clk);
    mem_done = 0;
    chk(status == 2'd1, "R10 R7 ready", status, 1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < NWORDS; i++) begin
      gold[i] = 16'(i * 257) ^ 16'h5a5a;
      dram[i] = gold[i];
    end
    repeat (3) @(negedge clk);
    chk(status == 2'd0, "R1 reset status", status, 0);
    rst_n = 1;
    chk(status == 2'd0, "R1 still reset before edge", status, 0);
    @(negedge clk);
    chk(status == 2'd1, "R1 ready", status, 1);
    chk(!rd_valid && !mem_cmd_valid, "R9 idle outputs", rd_valid, 0);

    do_write(13, 16'h0019, 0);
    for (int k = 0; k < 8; k++) do_write(16 + k, 16'h1000 + 16'(k * 17), 0);
    do_write(63, 16'hbeef, 0);
    do_write(40, 16'h4040, 1);
    do_read(13, 0);
    do_read(12, 1);
    for (int k = 0; k < 8; k++) do_read(16 + k, k[0]);
    do_read(63, 1);
    do_read(41, 0);
    do_read(40, 1);
    do_refresh();
    do_read(9, 0);
    do_read(14, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule